// File: doc/BRIEF.md
# Bit-Destuffing Frame Receiver

This block sits behind a clock-and-data recovery stage. It takes a serial stream of recovered bits, each marked by a valid strobe. It hunts for a short run of ones that opens a frame and aligns to the bit that follows that run. From that point it removes the ones that the sender inserted to break up long runs of zeros. It then collects a 16-bit header and delivers the payload as 16-bit words.

The header gives the payload length in words. Each payload word is presented for one cycle together with start-of-frame and end-of-frame flags. A zero found where a stuffed one is required is reported as a stuffing error, and the receiver falls back to hunting for the next frame. The zero-run count used for destuffing runs without a break across the header, the payload words and the end of the frame. A frame that ends on a full run of zeros therefore still has its trailing stuffed one removed.

Top module: `frm_destuff_rx`

## Requirements
- R1: After reset the receiver is hunting for a preamble, and `o_word_vld`, `o_sof`, `o_eof` and `o_err` are all low.
- R2: A frame is recognised only after three consecutive valid ones. The header starts with the next valid bit. A run of one or two ones followed by a zero is not recognised as a frame.
- R3: After six consecutive valid zeros inside a frame, the next valid bit is a stuffed one and is discarded. This applies in the header and in the payload.
- R4: If the bit after six zeros inside a frame is a zero, `o_err` pulses high for one cycle. The partly collected word is dropped and the receiver returns to hunting.
- R5: The header is sent most significant bit first. Its bits [9:0] give the payload word count, and bits [15:10] have no effect on the frame.
- R6: Payload words are sent most significant bit first. Each word appears on `o_word` with `o_word_vld` high for exactly one cycle, starting in the cycle after the clock edge that samples its 16th destuffed bit.
- R7: `o_sof` is high together with the first payload word of a frame, and `o_eof` is high together with the last one.
- R8: A header whose count is zero ends the frame with no payload words, and the receiver returns to hunting.
- R9: The zero-run count is not cleared at the boundary between the header and the payload, or at the boundary between two words. It is cleared only when a new preamble is recognised.
- R10: If a frame ends on a run of six zeros, the bit that follows is treated as a stuffed bit. A one there is discarded and does not count toward the next preamble. A zero there raises `o_err`.
- R11: Cycles with `bit_vld` low are ignored, whatever the value of `bit_dat`.
- R12: A synchronous active-high `rst` aborts any frame in progress. While `rst` is high all outputs are low, and afterwards the receiver hunts for a preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | A recovered bit is present this cycle |
| bit_dat | input | 1 | Recovered bit value |
| o_word | output | 16 | Destuffed payload word |
| o_word_vld | output | 1 | `o_word` is valid this cycle |
| o_sof | output | 1 | First payload word of a frame |
| o_eof | output | 1 | Last payload word of a frame |
| o_err | output | 1 | One-cycle stuffing-violation pulse |

## Verification
Frames are sent with a mix of header values:
- a header that itself needs a stuffed bit,
- a header with its unused upper bits set,
- a header with a zero count,
- the longest possible all-zero payload, so that nearly every seventh line bit is a stuffed one.

Words of dense ones, of alternating patterns and of trailing zeros separate a correct count of the zero run from one that is cleared at word boundaries. Runs of one or two ones, and a trailing stuffed one followed straight away by two ones, tell correct preamble alignment apart from early locking. Gaps in which `bit_dat` is held high, zeros placed where a stuffed one belongs, and a reset in the middle of a frame exercise the error and recovery paths.

// File: rtl/frm_pkg.sv
package frm_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2,
    ST_TAIL = 2'd3
  } frm_state_e;

endpackage

// File: rtl/frm_destuff.sv
module frm_destuff #(
  parameter int RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic in_vld,
  input  logic in_bit,
  output logic out_vld,
  output logic out_bit,
  output logic drop,
  output logic err,
  output logic run_full_nxt
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(RUN_LEN);

  logic [RW-1:0] run_q, run_d;
  logic          slot, take;

  // next zero-run length after one line bit
  function automatic logic [RW-1:0] next_run(input logic [RW-1:0] cur,
                                             input logic b,
                                             input logic at_slot);
    if (at_slot || b) return '0;
    return cur + RW'(1);
  endfunction

  assign slot = (run_q == RUN_MAX);
  assign take = en && in_vld;

  always_comb begin
    out_vld      = take && !slot;
    out_bit      = in_bit;
    drop         = take && slot && in_bit;
    err          = take && slot && !in_bit;
    run_d        = take ? next_run(run_q, in_bit, slot) : run_q;
    run_full_nxt = (run_d == RUN_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) run_q <= '0;
    else            run_q <= run_d;
  end

  p_run_bound_r3: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_MAX);
  p_drop_clears_run_r3: assert property (@(posedge clk) disable iff (rst)
    drop |=> run_q == '0);
  p_no_data_in_slot_r4: assert property (@(posedge clk) disable iff (rst)
    (err || drop) |-> !out_vld);

endmodule

// File: rtl/frm_sync_hunt.sv
module frm_sync_hunt #(
  parameter int PRE_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic in_vld,
  input  logic in_bit,
  output logic found
);
  localparam int PW = $clog2(PRE_LEN + 1);
  localparam logic [PW-1:0] LAST = PW'(PRE_LEN - 1);

  logic [PW-1:0] ones_q;

  assign found = en && in_vld && in_bit && (ones_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en)   ones_q <= '0;
    else if (in_vld)  ones_q <= (in_bit && !found) ? ones_q + PW'(1) : '0;
  end

  p_ones_bound_r2: assert property (@(posedge clk) disable iff (rst)
    ones_q <= LAST);
  p_found_restarts_r2: assert property (@(posedge clk) disable iff (rst)
    found |=> ones_q == '0);

endmodule

// File: rtl/frm_word_asm.sv
module frm_word_asm #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_vld,
  input  logic              in_bit,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  localparam int IW = $clog2(WORD_W);
  localparam logic [IW-1:0] LAST = IW'(WORD_W - 1);

  logic [IW-1:0]     idx_q;
  logic [WORD_W-2:0] sh_q;

  assign word = {sh_q, in_bit};
  assign done = in_vld && (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx_q <= '0;
      sh_q  <= '0;
    end else if (in_vld) begin
      idx_q <= done ? '0 : idx_q + IW'(1);
      sh_q  <= word[WORD_W-2:0];
    end
  end

  p_done_wraps_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> idx_q == '0);

endmodule

// File: rtl/frm_destuff_rx.sv
module frm_destuff_rx #(
  parameter int WORD_W  = 16,
  parameter int LEN_W   = 10,
  parameter int RUN_LEN = 6,
  parameter int PRE_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              bit_dat,
  output logic [WORD_W-1:0] o_word,
  output logic              o_word_vld,
  output logic              o_sof,
  output logic              o_eof,
  output logic              o_err
);
  import frm_pkg::*;

  frm_state_e        state_q;
  logic [LEN_W-1:0]  remain_q;
  logic              first_q;

  // named internal events
  logic              ev_lock, ev_bit, ev_bit_val, ev_drop, ev_viol, ev_tail_due;
  logic              ev_word, asm_vld, asm_clr;
  logic [WORD_W-1:0] asm_word;
  logic              in_frame;

  function automatic logic [LEN_W-1:0] hdr_count(input logic [WORD_W-1:0] h);
    return h[LEN_W-1:0];
  endfunction

  assign in_frame = (state_q != ST_HUNT);
  assign asm_vld  = ev_bit && (state_q == ST_HDR || state_q == ST_PAY);
  assign asm_clr  = ev_lock || ev_viol;

  frm_sync_hunt #(.PRE_LEN(PRE_LEN)) u_hunt (
    .clk(clk), .rst(rst), .en(!in_frame),
    .in_vld(bit_vld), .in_bit(bit_dat), .found(ev_lock)
  );

  frm_destuff #(.RUN_LEN(RUN_LEN)) u_dst (
    .clk(clk), .rst(rst), .clr(ev_lock), .en(in_frame),
    .in_vld(bit_vld), .in_bit(bit_dat),
    .out_vld(ev_bit), .out_bit(ev_bit_val), .drop(ev_drop),
    .err(ev_viol), .run_full_nxt(ev_tail_due)
  );

  frm_word_asm #(.WORD_W(WORD_W)) u_asm (
    .clk(clk), .rst(rst), .clr(asm_clr),
    .in_vld(asm_vld), .in_bit(ev_bit_val),
    .done(ev_word), .word(asm_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_HUNT;
      remain_q   <= '0;
      first_q    <= 1'b0;
      o_word     <= '0;
      o_word_vld <= 1'b0;
      o_sof      <= 1'b0;
      o_eof      <= 1'b0;
      o_err      <= 1'b0;
    end else begin
      o_word_vld <= 1'b0;
      o_sof      <= 1'b0;
      o_eof      <= 1'b0;
      o_err      <= 1'b0;
      if (in_frame && ev_viol) begin
        o_err   <= 1'b1;
        state_q <= ST_HUNT;
      end else begin
        unique case (state_q)
          ST_HUNT: if (ev_lock) state_q <= ST_HDR;
          ST_HDR: if (ev_word) begin
            if (hdr_count(asm_word) == '0) begin
              state_q <= ev_tail_due ? ST_TAIL : ST_HUNT;
            end else begin
              state_q  <= ST_PAY;
              remain_q <= hdr_count(asm_word);
              first_q  <= 1'b1;
            end
          end
          ST_PAY: if (ev_word) begin
            o_word     <= asm_word;
            o_word_vld <= 1'b1;
            o_sof      <= first_q;
            o_eof      <= (remain_q == LEN_W'(1));
            first_q    <= 1'b0;
            remain_q   <= remain_q - LEN_W'(1);
            if (remain_q == LEN_W'(1))
              state_q <= ev_tail_due ? ST_TAIL : ST_HUNT;
          end
          ST_TAIL: if (ev_drop) state_q <= ST_HUNT;
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end

  p_reset_quiet_r12: assert property (@(posedge clk)
    rst |=> !o_word_vld && !o_err && !o_sof && !o_eof && state_q == ST_HUNT);
  p_vld_from_pay_r6: assert property (@(posedge clk) disable iff (rst)
    o_word_vld |-> $past(state_q) == ST_PAY);
  p_sof_with_vld_r7: assert property (@(posedge clk) disable iff (rst)
    o_sof |-> o_word_vld);
  p_eof_with_vld_r7: assert property (@(posedge clk) disable iff (rst)
    o_eof |-> o_word_vld);
  p_err_to_hunt_r4: assert property (@(posedge clk) disable iff (rst)
    o_err |-> state_q == ST_HUNT && !o_word_vld);
  p_pay_has_count_r5: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_PAY |-> remain_q != '0);
  p_tail_after_zeros_r10: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_TAIL |-> !ev_bit);

endmodule

// File: tb/sim_frm_destuff_rx.sv
module sim_frm_destuff_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_vld = 1'b0;
  logic        bit_dat = 1'b0;
  logic [15:0] o_word;
  logic        o_word_vld, o_sof, o_eof, o_err;

  always #10 clk = ~clk;

  frm_destuff_rx u0 (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_dat(bit_dat),
    .o_word(o_word), .o_word_vld(o_word_vld), .o_sof(o_sof),
    .o_eof(o_eof), .o_err(o_err)
  );

  int          checks = 0;
  int          fails  = 0;
  int          err_seen = 0;
  int          zr = 0;
  bit          gap_en = 1'b0;
  bit          drv_prev = 1'b0;
  bit          raw_q[$];
  logic [15:0] pay_q[$];
  logic [17:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) drv_prev <= bit_vld;

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (o_err) err_seen++;
      if (o_word_vld) begin
        chk(drv_prev, "R6 word not right after a sampled bit", 32'(drv_prev), 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6/R7 unexpected word", {14'd0, o_sof, o_eof, o_word}, 0);
        end else begin
          logic [17:0] e;
          e = exp_q.pop_front();
          chk({o_sof, o_eof, o_word} == e, "R6/R7 word/sof/eof",
              {14'd0, o_sof, o_eof, o_word}, {14'd0, e});
        end
      end
    end
  end

  // sender-side stuffing, restated from the requirements
  task automatic add_data(input bit b);
    raw_q.push_back(b);
    if (b) zr = 0;
    else begin
      zr++;
      if (zr == 6) begin
        raw_q.push_back(1'b1);
        zr = 0;
      end
    end
  endtask

  task automatic build_frame(input logic [15:0] hdr, input bit push_exp);
    int n;
    raw_q.delete();
    zr = 0;
    repeat (3) raw_q.push_back(1'b1);
    for (int i = 15; i >= 0; i--) add_data(hdr[i]);
    n = int'(hdr[9:0]);
    for (int w = 0; w < n; w++) begin
      for (int i = 15; i >= 0; i--) add_data(pay_q[w][i]);
      if (push_exp) exp_q.push_back({w == 0, w == n - 1, pay_q[w]});
    end
  endtask

  task automatic play(input int limit);
    int k = 0;
    foreach (raw_q[j]) begin
      if (limit >= 0 && k >= limit) break;
      if (gap_en) begin
        @(negedge clk);
        bit_vld = 1'b0;
        bit_dat = 1'b1;
      end
      @(negedge clk);
      bit_vld = 1'b1;
      bit_dat = raw_q[j];
      k++;
    end
    @(negedge clk);
    bit_vld = 1'b0;
    bit_dat = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bit_vld = 1'b1;
      bit_dat = 1'b0;
    end
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic raw_bits(input logic [7:0] bits, input int n);
    raw_q.delete();
    for (int i = n - 1; i >= 0; i--) raw_q.push_back(bits[i]);
    play(-1);
  endtask

  task automatic drain(input string req);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int e0;
    // R1 / R12: outputs low in reset
    repeat (3) @(negedge clk);
    chk({o_word_vld, o_sof, o_eof, o_err} == 4'b0, "R1 reset outputs",
        {o_word_vld, o_sof, o_eof, o_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({o_word_vld, o_err} == 2'b0, "R1 idle after reset", {o_word_vld, o_err}, 0);

    // R2: short runs of ones are not a preamble
    idle(8);
    raw_bits(8'b0110_1101, 8);
    idle(20);
    chk(err_seen == 0, "R2 no lock on short ones", err_seen, 0);
    drain("R2 no words from short ones");

    // R3 R5 R6 R7: header that needs stuffing, mixed words
    pay_q = '{16'hA5C3, 16'h8001, 16'hFFFF};
    build_frame(16'h0003, 1'b1); play(-1); idle(6);
    drain("R3 R6 frame with stuffed header");

    // R5 R9: unused header bits set, zero run spans header/payload and words
    pay_q = '{16'h0000, 16'h0040};
    build_frame(16'hFC02, 1'b1); play(-1); idle(6);
    drain("R5 R9 upper header bits ignored");

    // R8: count zero, then a normal frame
    build_frame(16'h7C00, 1'b1); play(-1); idle(6);
    drain("R8 header-only frame emits nothing");
    pay_q = '{16'h3C3C};
    build_frame(16'h0001, 1'b1); play(-1); idle(6);
    drain("R8 frame after header-only");

    // R10: trailing stuffed one must not join the next preamble
    pay_q = '{16'hFFC0};
    build_frame(16'h0001, 1'b1); play(-1);
    raw_bits(8'b0000_0011, 2);
    idle(12);
    drain("R10 trailing stuff bit consumed");
    chk(err_seen == 0, "R10 no error after tail", err_seen, 0);
    pay_q = '{16'h1234, 16'h0F0F};
    build_frame(16'h0002, 1'b1); play(-1); idle(6);
    drain("R10 next frame aligned");

    // R11: gaps with bit_dat held high
    gap_en = 1'b1;
    pay_q = '{16'h0001, 16'h8000, 16'h0300};
    build_frame(16'h0003, 1'b1); play(-1); idle(6);
    gap_en = 1'b0;
    drain("R11 gaps ignored");

    // R4: zero in a stuff slot of the payload
    e0 = err_seen;
    pay_q = '{16'h0000, 16'h0000};
    build_frame(16'h0002, 1'b0);
    while (raw_q.size() > 3 + 17) void'(raw_q.pop_back());
    for (int i = 0; i < 10; i++) raw_q.push_back(1'b0);
    play(-1); idle(10);
    chk(err_seen == e0 + 1, "R4 stuffing error pulse", err_seen - e0, 1);
    drain("R4 partial word dropped");
    pay_q = '{16'hBEEF};
    build_frame(16'h0001, 1'b1); play(-1); idle(6);
    drain("R4 recovery frame");

    // R10: zero where the trailing stuffed one belongs
    e0 = err_seen;
    pay_q = '{16'hFFC0};
    build_frame(16'h0001, 1'b1);
    void'(raw_q.pop_back());
    raw_q.push_back(1'b0);
    play(-1); idle(6);
    chk(err_seen == e0 + 1, "R10 tail violation error", err_seen - e0, 1);
    drain("R10 word before tail violation");

    // R12: reset in the middle of a frame
    pay_q = '{16'h5555, 16'hAAAA, 16'h7777};
    build_frame(16'h0003, 1'b0); play(30);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk({o_word_vld, o_err} == 2'b0, "R12 outputs low in reset", {o_word_vld, o_err}, 0);
    @(negedge clk); rst = 1'b0;
    pay_q = '{16'hC001};
    build_frame(16'h0001, 1'b1); play(-1); idle(6);
    drain("R12 frame after mid-frame reset");

    // R3 R9: longest all-zero payload, header 0000001111111111
    pay_q.delete();
    for (int i = 0; i < 1023; i++) pay_q.push_back(16'h0000);
    build_frame(16'h03FF, 1'b1);
    chk(raw_q.size() == 19116, "R3 worst-case line length", raw_q.size(), 19116);
    play(-1); idle(6);
    drain("R3 R9 worst-case frame");
    chk(err_seen == 2, "R4 total error pulses", err_seen, 2);

    summary();
  end

endmodule